// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

This block is a register-mapped watchdog that sits on a simple 32-bit peripheral bus with a setup and an access phase and no wait states. Once software sets the run bit, a counter advances on every tick of the chosen time base. The time base is either each bus clock cycle or a pulse on an external tick input that has already been synchronised. When the first, interrupt-stage period runs out, a sticky status flag is set and the interrupt output may rise. Software then has a second, reset-stage period to restart the counter. If it does not, the block drives a one-cycle system reset request. Both periods are powers of two, and each is chosen by its own code in the control register.

The control and restart registers are protected. A write to either one takes effect only when the write just before it on the bus put the unlock key into the unlock register. That unlock is used up by the next write, whatever the address. A restart also needs its own key value. The FSM has four states:
- ST_OFF: stopped.
- ST_WAIT_INT: counting the interrupt period.
- ST_WAIT_RST: counting the reset period.
- ST_SPENT: reset already requested.

The transitions are:
- start: ST_OFF to ST_WAIT_INT when the run bit is set.
- stop: any state to ST_OFF when the run bit is cleared.
- kick: any running state to ST_WAIT_INT on a valid restart.
- int_expire: ST_WAIT_INT to ST_WAIT_RST.
- rst_expire: ST_WAIT_RST to ST_SPENT.

Top module: `wdog_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, and irq and sys_rst are low.
- R2: A write to the unlock register (offset 0x18) with data 0x5AA5 arms a single unlock. A write to control (0x10) or restart (0x14) takes effect only if the write just before it was that arming write. Every write, to any offset, clears the unlock. Unprotected writes are status writes and writes to the unlock register with other data.
- R3: Control reads back bits [10:0] as written, with bits above 10 reading 0. The fields are:
  - bit 0: run.
  - bit 1: time base, 1 = bus clock, 0 = external tick.
  - bit 2: interrupt output enable.
  - bit 3: reset output enable.
  - bits [7:4]: interrupt-period code.
  - bits [10:8]: reset-period code.
- R4: Interrupt-period codes 0..15 select 2^6, 2^8, 2^10, 2^11, 2^12, 2^13, 2^14, 2^15, 2^17, 2^19, 2^21, 2^23, 2^25, 2^27, 2^29 and 2^31 ticks. Status bit 0 (offset 0x1C) is set P bus cycles after the clock edge that captures the restart, or P+1 cycles after the edge that captures the run bit.
- R5: R ticks after the interrupt expiry, sys_rst is high for exactly one cycle if control bit 3 is set. R is 2^(7+code) for reset codes 0..7. If bit 3 is clear, there is no pulse.
- R6: An unlocked write of exactly 0xCAFE to restart clears the counter and returns the block to the interrupt stage. Any other value has no effect.
- R7: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R8: irq is status bit 0 gated by control bit 2. The flag is still set when bit 2 is clear.
- R9: Clearing the run bit stops the block and clears the counter. A later start counts the full period again.
- R10: With control bit 1 clear, the counter advances only on cycles where ext_tick is high.
- R11: Offset 0x00 reads the ID_VALUE parameter, and writes to it are ignored.
- R12: After a reset request, no further request is made until a restart or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, zero when not reading |
| ext_tick | input | 1 | Synchronised external tick, one cycle per tick |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with the default widths (8-bit offsets, 32-bit data, 32-bit counter) and overrides ID_VALUE with a value that is not zero, so the ID read is a real check. With the bus clock as the time base, interrupt codes 0 to 2 and reset codes 0 and 1 expire within a few thousand cycles. This makes the exact expiry edges, the restart races in both stages and the gating of the reset request observable. Longer codes are covered only through the same decode path and are not run to expiry. A divide-by-four tick on ext_tick exercises the external time base.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [7:0] OFS_ID     = 8'h00;
    localparam logic [7:0] OFS_CTRL   = 8'h10;
    localparam logic [7:0] OFS_KICK   = 8'h14;
    localparam logic [7:0] OFS_UNLOCK = 8'h18;
    localparam logic [7:0] OFS_STAT   = 8'h1C;

    localparam logic [15:0] UNLOCK_KEY = 16'h5AA5;
    localparam logic [15:0] KICK_KEY   = 16'hCAFE;

    localparam int CTRL_W = 11;

    typedef struct packed {
        logic [2:0] rst_sel;
        logic [3:0] int_sel;
        logic       rst_en;
        logic       int_en;
        logic       clk_bus;
        logic       run;
    } wd_ctrl_t;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_WAIT_INT = 2'd1,
        ST_WAIT_RST = 2'd2,
        ST_SPENT    = 2'd3
    } wd_state_e;

endpackage

// File: rtl/wdog_period_dec.sv
module wdog_period_dec #(
    parameter int CNT_W = 32
) (
    input  logic [3:0]       int_sel,
    input  logic [2:0]       rst_sel,
    output logic [CNT_W-1:0] int_term,
    output logic [CNT_W-1:0] rst_term
);
    localparam int SH_W = $clog2(CNT_W);

    logic [SH_W-1:0] int_sh;
    logic [SH_W-1:0] rst_sh;

    always_comb begin
        case (int_sel)
            4'd0:    int_sh = SH_W'(6);
            4'd1:    int_sh = SH_W'(8);
            4'd2:    int_sh = SH_W'(10);
            4'd3:    int_sh = SH_W'(11);
            4'd4:    int_sh = SH_W'(12);
            4'd5:    int_sh = SH_W'(13);
            4'd6:    int_sh = SH_W'(14);
            4'd7:    int_sh = SH_W'(15);
            4'd8:    int_sh = SH_W'(17);
            4'd9:    int_sh = SH_W'(19);
            4'd10:   int_sh = SH_W'(21);
            4'd11:   int_sh = SH_W'(23);
            4'd12:   int_sh = SH_W'(25);
            4'd13:   int_sh = SH_W'(27);
            4'd14:   int_sh = SH_W'(29);
            default: int_sh = SH_W'(31);
        endcase
        rst_sh   = SH_W'(rst_sel) + SH_W'(7);
        // terminal count is one below the period length
        int_term = (CNT_W'(1) << int_sh) - CNT_W'(1);
        rst_term = (CNT_W'(1) << rst_sh) - CNT_W'(1);
    end
endmodule

// File: rtl/wdog_bus_regs.sv
module wdog_bus_regs
    import wdog_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              int_fire,
    output wd_ctrl_t          ctrl_q,
    output logic              unlock_q,
    output logic              status_q,
    output logic              kick
);
    logic wr;
    logic hit_ctrl;
    logic hit_kick;
    logic hit_unlock;
    logic hit_stat;

    assign wr         = psel && penable && pwrite;
    assign hit_ctrl   = wr && (paddr == ADDR_W'(OFS_CTRL));
    assign hit_kick   = wr && (paddr == ADDR_W'(OFS_KICK));
    assign hit_unlock = wr && (paddr == ADDR_W'(OFS_UNLOCK));
    assign hit_stat   = wr && (paddr == ADDR_W'(OFS_STAT));

    // restart needs both a live unlock and the exact key
    assign kick = hit_kick && unlock_q && (pwdata == DATA_W'(KICK_KEY));

    // unlock lives for exactly one following write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlock_q <= 1'b0;
        end else if (wr) begin
            unlock_q <= hit_unlock && (pwdata == DATA_W'(UNLOCK_KEY));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (hit_ctrl && unlock_q) begin
            ctrl_q <= wd_ctrl_t'(pwdata[CTRL_W-1:0]);
        end
    end

    // expiry has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (int_fire) begin
            status_q <= 1'b1;
        end else if (hit_stat && pwdata[0]) begin
            status_q <= 1'b0;
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (paddr)
                ADDR_W'(OFS_ID):   prdata = ID_VALUE;
                ADDR_W'(OFS_CTRL): prdata = DATA_W'(ctrl_q);
                ADDR_W'(OFS_STAT): prdata = DATA_W'(status_q);
                default:           prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clk_bus,
    input  logic             rst_en,
    input  logic             ext_tick,
    input  logic             kick,
    input  logic [CNT_W-1:0] int_term,
    input  logic [CNT_W-1:0] rst_term,
    output logic             int_fire,
    output logic             sys_rst
);
    wd_state_e        state_q;
    wd_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             int_hit;
    logic             rst_hit;
    logic             rst_fire;

    assign tick    = clk_bus ? 1'b1 : ext_tick;
    assign int_hit = (state_q == ST_WAIT_INT) && tick && (cnt_q == int_term);
    assign rst_hit = (state_q == ST_WAIT_RST) && tick && (cnt_q == rst_term);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: start, stop, kick, int_expire, rst_expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run) state_d = ST_WAIT_INT;
            end
            ST_WAIT_INT: begin
                if (!run)         state_d = ST_OFF;
                else if (kick)    state_d = ST_WAIT_INT;
                else if (int_hit) state_d = ST_WAIT_RST;
            end
            ST_WAIT_RST: begin
                if (!run)         state_d = ST_OFF;
                else if (kick)    state_d = ST_WAIT_INT;
                else if (rst_hit) state_d = ST_SPENT;
            end
            ST_SPENT: begin
                if (!run)      state_d = ST_OFF;
                else if (kick) state_d = ST_WAIT_INT;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // one counter serves both stages, cleared on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || kick || (state_d != state_q)) begin
            cnt_q <= '0;
        end else if (tick && ((state_q == ST_WAIT_INT) || (state_q == ST_WAIT_RST))) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        int_fire = run && !kick && int_hit;
        rst_fire = run && !kick && rst_hit && rst_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_rst <= 1'b0;
        end else begin
            sys_rst <= rst_fire;
        end
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter int                CNT_W    = 32,
    parameter logic [DATA_W-1:0] ID_VALUE = DATA_W'(32'h0001_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              ext_tick,
    output logic              irq,
    output logic              sys_rst
);
    wd_ctrl_t         ctrl_q;
    logic             unlock_q;
    logic             status_q;
    logic             kick;
    logic             int_fire;
    logic [CNT_W-1:0] int_term;
    logic [CNT_W-1:0] rst_term;

    wdog_bus_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ID_VALUE(ID_VALUE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .int_fire(int_fire),
        .ctrl_q  (ctrl_q),
        .unlock_q(unlock_q),
        .status_q(status_q),
        .kick    (kick)
    );

    wdog_period_dec #(
        .CNT_W(CNT_W)
    ) u_dec (
        .int_sel (ctrl_q.int_sel),
        .rst_sel (ctrl_q.rst_sel),
        .int_term(int_term),
        .rst_term(rst_term)
    );

    wdog_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.run),
        .clk_bus (ctrl_q.clk_bus),
        .rst_en  (ctrl_q.rst_en),
        .ext_tick(ext_tick),
        .kick    (kick),
        .int_term(int_term),
        .rst_term(rst_term),
        .int_fire(int_fire),
        .sys_rst (sys_rst)
    );

    assign irq = status_q && ctrl_q.int_en;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              wdata0,
    input logic [DATA_W-1:0] prdata,
    input logic              sys_rst,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              unlock_q,
    input logic              status_q
);
    a_r2_ctrl_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(unlock_q));

    a_r5_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst);

    a_r5_rst_gated: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> $past(ctrl_q[3]));

    a_r7_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_q) |-> $past(psel && penable && pwrite &&
                                  (paddr == ADDR_W'(OFS_STAT)) && wdata0));

    a_r9_off_no_rst: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_q[0]) |-> !sys_rst);

    a_r9_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_q[0]) |-> !$rose(status_q));

    a_r11_id_read: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && (paddr == ADDR_W'(OFS_ID))) |-> (prdata == ID_VALUE));
endmodule

bind wdog_top wdog_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ID_VALUE(ID_VALUE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .wdata0  (pwdata[0]),
    .prdata  (prdata),
    .sys_rst (sys_rst),
    .ctrl_q  (ctrl_q),
    .unlock_q(unlock_q),
    .status_q(status_q)
);

// File: tb/wdog_top_tb.sv
`timescale 1ns/1ps
module wdog_top_tb;
    localparam logic [31:0] TB_ID = 32'h5744_0102;
    localparam logic [7:0] A_ID = 8'h00, A_CTRL = 8'h10, A_KICK = 8'h14,
                           A_UNL = 8'h18, A_STAT = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        ext_tick = 1'b0;
    logic        irq, sys_rst;

    int nchk = 0, nfail = 0;
    int cyc = 0, wr_cyc = 0;
    int irq_at = 0, rst_at = 0, rst_cnt = 0;
    int ext_div = 0;

    wdog_top #(.ID_VALUE(TB_ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_tick(ext_tick),
        .irq(irq), .sys_rst(sys_rst)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        ext_div  = (ext_div + 1) % 4;
        ext_tick = (ext_div == 0);
        if (irq && irq_at == 0) irq_at = cyc;
        if (sys_rst) begin
            rst_cnt = rst_cnt + 1;
            rst_at  = cyc;
        end
    end

    function automatic int int_exp(input int c);
        if (c < 2)      return 2 * c + 6;
        else if (c < 8) return c + 8;
        else            return 2 * c + 1;
    endfunction

    function automatic int rst_len(input int r);
        return 1 << (r + 7);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        wr_cyc = cyc;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic prot_wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr(A_UNL, 32'h5AA5);
        bus_wr(a, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fresh();
        prot_wr(A_CTRL, 32'h0);
        bus_wr(A_STAT, 32'h1);
        idle(2);
        irq_at = 0; rst_at = 0; rst_cnt = 0;
    endtask

    function automatic logic [31:0] ctrl_word(input bit bus, input bit ien, input bit ren,
                                              input int c, input int r);
        return 32'(1 | (int'(bus) << 1) | (int'(ien) << 2) | (int'(ren) << 3) | (c << 4) | (r << 8));
    endfunction

    task automatic run_case(input int c, input int r, input bit ren);
        int e, p, rl;
        logic [31:0] d;
        fresh();
        prot_wr(A_CTRL, ctrl_word(1, 1, ren, c, r));
        e  = wr_cyc;
        p  = 1 << int_exp(c);
        rl = rst_len(r);
        idle(p + rl + 20);
        chk($sformatf("R4 irq edge c=%0d", c), irq_at, e + 1 + p);
        if (ren) begin
            chk($sformatf("R5 rst edge r=%0d", r), rst_at, e + 1 + p + rl);
            chk("R5 single pulse", rst_cnt, 1);
        end else begin
            chk("R5 no pulse when disabled", rst_cnt, 0);
        end
        idle(300);
        chk("R12 no repeat request", rst_cnt, ren ? 1 : 0);
        bus_rd(A_STAT, d);
        chk("R4 status set", d, 1);
    endtask

    logic [31:0] rd;
    logic [10:0] m_ctrl;
    bit          m_unl;
    int          e0, k0, k1;

    initial begin
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state, R11 id
        bus_rd(A_CTRL, rd); chk("R1 ctrl reset", rd, 0);
        bus_rd(A_STAT, rd); chk("R1 status reset", rd, 0);
        chk("R1 irq reset", irq, 0);
        chk("R1 sys_rst reset", sys_rst, 0);
        bus_rd(A_ID, rd); chk("R11 id value", rd, TB_ID);
        prot_wr(A_ID, 32'h1234_5678);
        bus_rd(A_ID, rd); chk("R11 id ignores write", rd, TB_ID);

        // R2 lock behaviour
        bus_wr(A_CTRL, 32'h6A6);
        bus_rd(A_CTRL, rd); chk("R2 locked ctrl write", rd, 0);
        bus_wr(A_UNL, 32'h5AA5);
        bus_wr(A_STAT, 32'h0);
        bus_wr(A_CTRL, 32'h6A6);
        bus_rd(A_CTRL, rd); chk("R2 unlock consumed by other write", rd, 0);
        bus_wr(A_UNL, 32'h5AA4);
        bus_wr(A_CTRL, 32'h6A6);
        bus_rd(A_CTRL, rd); chk("R2 wrong key", rd, 0);

        // R3 field readback
        prot_wr(A_CTRL, 32'hFFFF_F6A6);
        bus_rd(A_CTRL, rd); chk("R3 ctrl readback masked", rd, 32'h6A6);
        bus_wr(A_CTRL, 32'h0);
        bus_rd(A_CTRL, rd); chk("R2 one unlock one write", rd, 32'h6A6);

        // R2 random sequences against a model (timer kept stopped)
        prot_wr(A_CTRL, 32'h0);
        m_ctrl = '0; m_unl = 1'b0;
        for (int i = 0; i < 300; i++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 6);
            d  = $urandom;
            case (op)
                0: begin bus_wr(A_UNL, 32'h5AA5); m_unl = 1'b1; end
                1: begin
                    if (d[0]) d = 32'h5AA5;
                    bus_wr(A_UNL, d); m_unl = (d == 32'h5AA5);
                end
                2: begin
                    d = d & 32'hFFFF_FFFE;
                    bus_wr(A_CTRL, d);
                    if (m_unl) m_ctrl = d[10:0];
                    m_unl = 1'b0;
                end
                3: begin bus_wr(A_STAT, d); m_unl = 1'b0; end
                4: begin bus_wr(A_ID, d); m_unl = 1'b0; end
                default: begin bus_wr(A_KICK, d); m_unl = 1'b0; end
            endcase
            bus_rd(A_CTRL, rd);
            chk("R2 random ctrl model", rd, {21'd0, m_ctrl});
        end

        // R4 R5 R12 period decode on several codes
        run_case(0, 0, 1'b1);
        run_case(1, 1, 1'b1);
        run_case(2, 0, 1'b1);
        run_case(0, 1, 1'b0);

        // R7 write-one-to-clear
        bus_wr(A_STAT, 32'h0);
        bus_rd(A_STAT, rd); chk("R7 write 0 keeps flag", rd, 1);
        bus_wr(A_STAT, 32'h1);
        bus_rd(A_STAT, rd); chk("R7 write 1 clears flag", rd, 0);

        // R8 interrupt gating
        fresh();
        prot_wr(A_CTRL, ctrl_word(1, 0, 0, 0, 0));
        idle(100);
        chk("R8 irq gated low", irq, 0);
        bus_rd(A_STAT, rd); chk("R8 flag set while gated", rd, 1);
        prot_wr(A_CTRL, ctrl_word(1, 1, 0, 0, 0));
        idle(1);
        chk("R8 irq follows enable", irq, 1);

        // R6 restart in both stages
        fresh();
        prot_wr(A_CTRL, ctrl_word(1, 1, 1, 1, 1));
        idle(150);
        prot_wr(A_KICK, 32'hCAFE);
        k0 = wr_cyc;
        idle(300);
        chk("R6 kick restarts interrupt stage", irq_at, k0 + 256);
        idle(20);
        prot_wr(A_KICK, 32'hCAFE);
        k1 = wr_cyc;
        idle(560);
        chk("R6 kick in reset stage", rst_at, k1 + 512);
        chk("R6 one request after kick", rst_cnt, 1);

        // R6 invalid restarts
        fresh();
        prot_wr(A_CTRL, ctrl_word(1, 1, 1, 0, 0));
        e0 = wr_cyc;
        idle(20);
        prot_wr(A_KICK, 32'hBEEF);
        bus_wr(A_KICK, 32'hCAFE);
        idle(250);
        chk("R6 bad kicks ignored irq", irq_at, e0 + 1 + 64);
        chk("R6 bad kicks ignored rst", rst_at, e0 + 1 + 64 + 128);

        // R9 stop clears the counter
        fresh();
        prot_wr(A_CTRL, ctrl_word(1, 1, 0, 0, 0));
        idle(40);
        prot_wr(A_CTRL, 32'h0);
        idle(60);
        chk("R9 no expiry while stopped", irq_at, 0);
        prot_wr(A_CTRL, ctrl_word(1, 1, 0, 0, 0));
        e0 = wr_cyc;
        idle(100);
        chk("R9 full period after restart of run", irq_at, e0 + 1 + 64);

        // R10 external tick time base (one tick per four cycles)
        fresh();
        prot_wr(A_CTRL, ctrl_word(0, 1, 0, 0, 0));
        e0 = wr_cyc;
        idle(200);
        chk("R10 no expiry before ext ticks", irq_at, 0);
        idle(100);
        chk("R10 expiry near 256 cycles",
            ((irq_at - e0) >= 252 && (irq_at - e0) <= 262) ? 1 : 0, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nfail = nfail + 1;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule